// File: doc/BRIEF.md
# Serial Skew-Control Register Loader

This block is a write-only three-wire serial slave that loads four small control registers in a video skew-compensation path. An external controller frames each transfer with an active-low select line, toggles a serial clock and presents data on one line; the block samples all three inputs with its own faster system clock, detects the falling serial-clock edge and assembles 8-bit command words.

Each word carries a command bit, a register address and a payload. A write word steers its payload bit by bit into one of three per-channel delay codes (red, green, blue; each step is 2 ns, code 0 to 31 giving 0 to 62 ns) or into a test register holding a signed 4-bit comparator level (50 mV per step) and a test-mode flag. Payload bits enter the live register as they arrive, so a frame cut short leaves a partly shifted value behind. Several words may follow each other inside one select burst. The system clock must run at least four times faster than the serial clock, and the controller keeps serial-clock edges clear of select edges.

Top module: `skew_cfg_port`

## Requirements
- R1: After reset, all three delay codes, the test level and the test-mode flag read 0.
- R2: A word sent MSB first as command 0, address 01, then a 5-bit payload leaves that payload in the red delay code; other registers keep their values.
- R3: Address 10 loads the green delay code and address 11 loads the blue delay code, with the payload read MSB first.
- R4: A word whose first (command) bit is 1 changes no register, yet still consumes 8 serial clocks, so a write word following it in the same burst is decoded normally.
- R5: Within one select burst, every group of 8 falling serial-clock edges forms a new word.
- R6: Each payload bit shifts into the LSB of the addressed register one bit at a time; a frame ended after k payload bits (k < 5) leaves that register as its old value shifted left by k with the k new bits in the low positions.
- R7: The bit counter returns to the first (command) position whenever the select line is inactive, so the next frame starts a fresh word after a truncated one.
- R8: Address 00 loads the test register: the first four payload bits form the level code (two's complement, last of the four is the LSB, -8..7 meaning -400..+350 mV) and the fifth is the mode flag, 1 = test mode, 0 = normal.
- R9: Serial-clock edges while the select line is high change no register.
- R10: A reset asserted after registers have been written returns all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock, data taken on falling edge, idles high |
| ser_dat | input | 1 | Serial data, MSB first |
| red_dly | output | 5 | Red channel delay code (2 ns per step) |
| grn_dly | output | 5 | Green channel delay code |
| blu_dly | output | 5 | Blue channel delay code |
| tst_level | output | 4 | Signed comparator level code, 50 mV per step |
| tst_mode | output | 1 | Test-mode flag |

## Verification
The bench builds the block with its default parameters: 8-bit words, a 2-bit address, 5-bit registers and two synchronizer stages. With each serial bit held for 16 system clocks, the ratio sits well above the 4x minimum, so every falling edge is seen exactly once and the directed scenarios reach the framing corners: read words skipped inside a burst, back-to-back words in one burst, a frame cut after three payload bits and the recovery that follows, and clock toggling with the select line idle. The test-register scenario covers both the most negative level code and the largest positive one together with both mode values.

// File: rtl/skew_cfg_pkg.sv
package skew_cfg_pkg;
  localparam int unsigned SEL_IDX = 0;
  localparam int unsigned CLK_IDX = 1;
  localparam int unsigned DAT_IDX = 2;
  localparam int unsigned LINES   = 3;

  localparam int unsigned REG_TEST = 0;
  localparam int unsigned REG_RED  = 1;
  localparam int unsigned REG_GRN  = 2;
  localparam int unsigned REG_BLU  = 3;
endpackage

// File: rtl/skew_sync.sv
module skew_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= async_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/skew_word_fsm.sv
module skew_word_fsm #(
  parameter int unsigned WORD_BITS = 8,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_act,
  input  logic              sclk_s,
  input  logic              dat_s,
  output logic              sh_vld,
  output logic [ADDR_W-1:0] sh_addr,
  output logic              sh_bit
);
  localparam int unsigned CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W);

  logic              sclk_prev_q;
  logic              fall;
  logic              take;
  logic [CNT_W-1:0]  pos_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;

  assign fall = sclk_prev_q & ~sclk_s;
  assign take = fall & sel_act;

  always_ff @(posedge clk) begin
    if (rst) sclk_prev_q <= 1'b1;
    else     sclk_prev_q <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else if (!sel_act) begin
      pos_q <= '0;
    end else if (take) begin
      if (pos_q == '0) rd_q <= dat_s;
      else if (pos_q <= ADDR_END) addr_q <= {addr_q[ADDR_W-2:0], dat_s};
      pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_vld  <= 1'b0;
      sh_addr <= '0;
      sh_bit  <= 1'b0;
    end else begin
      sh_vld  <= take && (pos_q > ADDR_END) && !rd_q;
      sh_addr <= addr_q;
      sh_bit  <= dat_s;
    end
  end

  // R4: payload bits of a read word never produce a shift strobe
  p_read_noshift_r4: assert property (@(posedge clk) disable iff (rst)
    (take && rd_q && pos_q > ADDR_END) |=> !sh_vld);

  // R7: an inactive select returns the word position to the command bit
  p_idle_restart_r7: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> (pos_q == '0));
endmodule

// File: rtl/skew_reg_bank.sv
module skew_reg_bank #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 5,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_vld,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic                             wr_bit,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  logic [NUM_REGS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      assign hit[g] = wr_vld && (wr_addr == ADDR_W'(g));

      always_ff @(posedge clk) begin
        if (rst)         regs_q[g] <= '0;
        else if (hit[g]) regs_q[g] <= {regs_q[g][DATA_W-2:0], wr_bit};
      end

      // R6: a strobe shifts exactly one bit into the addressed register's LSB
      p_shift_in_r6: assert property (@(posedge clk) disable iff (rst)
        hit[g] |=> regs_q[g] == {$past(regs_q[g][DATA_W-2:0]), $past(wr_bit)});
    end
  endgenerate

  // R9: without a strobe, every register holds
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_vld |=> $stable(regs_q));
endmodule

// File: rtl/skew_cfg_port.sv
module skew_cfg_port #(
  parameter int unsigned WORD_BITS   = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DLY_W       = 5,
  parameter int unsigned LVL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_sel_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  output logic [DLY_W-1:0] red_dly,
  output logic [DLY_W-1:0] grn_dly,
  output logic [DLY_W-1:0] blu_dly,
  output logic [LVL_W-1:0] tst_level,
  output logic             tst_mode
);
  import skew_cfg_pkg::*;

  localparam int unsigned NUM_REGS = 1 << ADDR_W;
  localparam logic [LINES-1:0] IDLE_LINES = LINES'((1 << SEL_IDX) | (1 << CLK_IDX));

  logic [LINES-1:0]               raw;
  logic [LINES-1:0]               syn;
  logic                           sh_vld;
  logic [ADDR_W-1:0]              sh_addr;
  logic                           sh_bit;
  logic [NUM_REGS-1:0][DLY_W-1:0] regs;

  always_comb begin
    raw          = '0;
    raw[SEL_IDX] = ser_sel_n;
    raw[CLK_IDX] = ser_clk;
    raw[DAT_IDX] = ser_dat;
  end

  skew_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LINES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw),
    .sync_o  (syn)
  );

  skew_word_fsm #(.WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .sel_act (~syn[SEL_IDX]),
    .sclk_s  (syn[CLK_IDX]),
    .dat_s   (syn[DAT_IDX]),
    .sh_vld  (sh_vld),
    .sh_addr (sh_addr),
    .sh_bit  (sh_bit)
  );

  skew_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DLY_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (sh_vld),
    .wr_addr (sh_addr),
    .wr_bit  (sh_bit),
    .regs_q  (regs)
  );

  assign red_dly   = regs[REG_RED];
  assign grn_dly   = regs[REG_GRN];
  assign blu_dly   = regs[REG_BLU];
  assign tst_level = regs[REG_TEST][DLY_W-1 -: LVL_W];
  assign tst_mode  = regs[REG_TEST][0];
endmodule

// File: tb/skew_cfg_port_bench.sv
module skew_cfg_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_sel_n = 1'b1;
  logic ser_clk = 1'b1;
  logic ser_dat = 1'b0;
  logic [4:0] red_dly, grn_dly, blu_dly;
  logic [3:0] tst_level;
  logic       tst_mode;

  int checks = 0;
  int errors = 0;
  int er, eg, eb, et;  // expected register images; et = {level, mode}

  always #2 clk = ~clk;  // 250 MHz

  skew_cfg_port u_skew_cfg_port (
    .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .red_dly(red_dly), .grn_dly(grn_dly),
    .blu_dly(blu_dly), .tst_level(tst_level), .tst_mode(tst_mode)
  );

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    errors++;
    checks++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    check({req, " red"}, red_dly, er);
    check({req, " green"}, grn_dly, eg);
    check({req, " blue"}, blu_dly, eb);
    check({req, " level"}, tst_level, et >> 1);
    check({req, " mode"}, tst_mode, et & 1);
  endtask

  task automatic send_bits(input logic [7:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = w[7-i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (8) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic frame_open();
    ser_sel_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame_close();
    repeat (8) @(negedge clk);
    ser_sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] w);
    frame_open();
    send_bits(w, 8);
    frame_close();
  endtask

  task automatic t_reset();
    er = 0; eg = 0; eb = 0; et = 0;
    check_all("R1 reset");
  endtask

  task automatic t_red();
    frame(8'b0_01_10101);
    er = 21;
    check_all("R2 red write");
  endtask

  task automatic t_green_blue();
    frame(8'b0_10_00111);
    eg = 7;
    check_all("R3 green write");
    frame(8'b0_11_11111);
    eb = 31;
    check_all("R3 blue write");
  endtask

  task automatic t_read_skip();
    frame_open();
    send_bits(8'b1_01_00000, 8);
    send_bits(8'b0_10_01010, 8);
    frame_close();
    eg = 10;  // red stays 21 (R4), second word lands (R5)
    check_all("R4 read word ignored, R5 next word");
  endtask

  task automatic t_burst();
    frame_open();
    send_bits(8'b0_01_00011, 8);
    send_bits(8'b0_11_10000, 8);
    send_bits(8'b0_10_00001, 8);
    frame_close();
    er = 3; eb = 16; eg = 1;
    check_all("R5 three-word burst");
  endtask

  task automatic t_test_reg();
    frame(8'b0_00_1000_1);
    et = 5'b1000_1;
    check_all("R8 level -8 test mode");
    frame(8'b0_00_0111_0);
    et = 5'b0111_0;
    check_all("R8 level 7 normal mode");
  endtask

  task automatic t_truncate();
    frame_open();
    send_bits(8'b0_01_110_00, 6);
    frame_close();
    er = ((er << 3) | 3'b110) & 5'h1f;  // 3 -> 30
    check_all("R6 truncated shift");
    frame(8'b0_01_00100);
    er = 4;
    check_all("R7 restart after truncation");
  endtask

  task automatic t_idle_clocks();
    send_bits(8'b0_01_11111, 8);
    send_bits(8'b0_00_11111, 8);
    repeat (8) @(negedge clk);
    check_all("R9 clocks with select high");
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    er = 0; eg = 0; eb = 0; et = 0;
    check_all("R10 reset after writes");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_red();
    t_green_blue();
    t_read_skip();
    t_burst();
    t_test_reg();
    t_truncate();
    t_idle_clocks();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule